// File: doc/BRIEF.md
# Single-Bin Recursive DFT Kernel

This kernel computes one chosen coefficient X[k] of the discrete Fourier transform of a real, fixed-length sample frame. It does not evaluate every bin with a butterfly network. It runs a complex one-pole recursion whose pole sits on the unit circle at the bin's angle. Each accepted sample is added to the running state, and the sum is then rotated by e^(+j2πk/N). After the last sample of the frame, the state equals X[k].

A frame opens with a start strobe, and the sample presented with that strobe is sample 0. Samples then arrive one per cycle on a valid qualifier, and idle cycles are allowed between them. The bin index is captured when the frame opens. Several kernels can sit on the same sample stream, each with its own bin, because no kernel shares state with another. This gives a sparse transform in which only the bins of interest cost hardware.

Top module: `sbin_dft_kernel`

## Requirements
- R1: While rst_ni is low, done_o is 0 and re_o and im_o are 0.
- R2: A cycle with start_i high clears the recursion state, zeroes re_o and im_o, and captures bin_i. If valid_i is high in that same cycle, that sample is sample 0 of the new frame. If valid_i is low, the frame holds no samples yet.
- R3: bin_i is read only in a start_i cycle. Changing it at any other time has no effect on the result.
- R4: After N valid samples x[0..N-1], re_o + j·im_o equals the sum over r of x[r]·e^(−j2πkr/N), where k is the captured bin_i read as an unsigned integer from 0 to N−1. Each part is within 0.015·Σ|x[r]| + N of the exact value.
- R5: done_o is high for exactly one cycle: the cycle after the clock edge that accepted the N-th valid sample. re_o and im_o carry the result in that same cycle.
- R6: Cycles with valid_i low add nothing to the sum and do not advance the sample count.
- R7: Once a frame has completed, further valid samples are ignored. re_o and im_o hold their values and done_o stays low until the next start_i.
- R8: When k is a multiple of N/4 (for example 0, N/4, N/2 or 3N/4), the result is exact, with no rounding error.
- R9: Full-scale input cannot overflow the state. With k = 0 and every sample at −2^(DATA_W−1), re_o is exactly −N·2^(DATA_W−1).
- R10: A start_i in the middle of a frame abandons the partial frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame-open strobe; clears state and captures the bin |
| valid_i | input | 1 | Qualifies sample_i |
| sample_i | input | DATA_W | Signed real sample |
| bin_i | input | log2(FRAME_LEN) | Bin index k, unsigned |
| re_o | output | DATA_W+log2(FRAME_LEN)+2 | Real part of X[k], signed |
| im_o | output | DATA_W+log2(FRAME_LEN)+2 | Imaginary part of X[k], signed |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the kernel with its defaults: a 1024-sample frame, 16-bit samples and 15 fractional coefficient bits, which gives a 28-bit state. At this size a full-scale constant frame at bin 0 drives the state to exactly −2^25, so headroom is tested at its real limit. The quarter-turn bins 256, 512 and 768 use coefficients of exactly 0 and ±1, so their results can be compared for exact equality with a floating-point DFT. Bins in all four quadrants of the coefficient table exercise every sign and mirror case of the lookup.

// File: rtl/sbdft_pkg.sv
package sbdft_pkg;

  typedef enum logic [1:0] {QD_0, QD_1, QD_2, QD_3} quad_e;

  localparam real TWO_PI = 6.283185307179586;

  // cos(2*pi*i/n) scaled by 2**frac, rounded to nearest
  function automatic int q_cos(input int i, input int n, input int frac);
    return $rtoi($floor((2.0 ** frac) * $cos(TWO_PI * i / n) + 0.5));
  endfunction

endpackage

// File: rtl/sbdft_twiddle.sv
module sbdft_twiddle
  import sbdft_pkg::*;
#(
  parameter int FRAME_LEN = 1024,
  parameter int COEF_FRAC = 15,
  parameter int K_W       = $clog2(FRAME_LEN),
  parameter int COEF_W    = COEF_FRAC + 2
) (
  input  logic [K_W-1:0]           k_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);
  localparam int Q   = FRAME_LEN / 4;
  localparam int R_W = K_W - 2;
  localparam int QW  = R_W + 1;

  logic signed [COEF_W-1:0] tab [Q+1];

  for (genvar i = 0; i <= Q; i++) begin : g_tab
    localparam int Val = q_cos(i, FRAME_LEN, COEF_FRAC);
    assign tab[i] = COEF_W'(Val);
  end

  quad_e                    quad;
  logic [QW-1:0]            ia, ib;
  logic signed [COEF_W-1:0] ta, tb;

  assign quad = quad_e'(k_i[K_W-1:K_W-2]);
  assign ia   = {1'b0, k_i[R_W-1:0]};
  assign ib   = QW'(Q) - ia;
  assign ta   = tab[ia];
  assign tb   = tab[ib];   // sin of the in-quadrant angle

  always_comb begin
    unique case (quad)
      QD_0: begin cos_o = ta;  sin_o = tb;  end
      QD_1: begin cos_o = -tb; sin_o = ta;  end
      QD_2: begin cos_o = -ta; sin_o = -tb; end
      default: begin cos_o = tb; sin_o = -ta; end
    endcase
  end

endmodule

// File: rtl/sbdft_rot_step.sv
module sbdft_rot_step #(
  parameter int ACC_W  = 28,
  parameter int DATA_W = 16,
  parameter int COEF_W = 17,
  parameter int FRAC   = 15
) (
  input  logic signed [ACC_W-1:0]  s_re_i,
  input  logic signed [ACC_W-1:0]  s_im_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [COEF_W-1:0] c_i,
  input  logic signed [COEF_W-1:0] s_i,
  output logic signed [ACC_W-1:0]  re_o,
  output logic signed [ACC_W-1:0]  im_o
);
  localparam int PW = ACC_W + COEF_W;
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (FRAC - 1));

  logic signed [PW-1:0] a_w, b_w, cw, sw, pr, pi;

  // add first, then rotate: state after the last sample is X[k] directly
  assign a_w = PW'(s_re_i) + PW'(x_i);
  assign b_w = PW'(s_im_i);
  assign cw  = PW'(c_i);
  assign sw  = PW'(s_i);
  assign pr  = a_w * cw - b_w * sw;
  assign pi  = a_w * sw + b_w * cw;

  assign re_o = ACC_W'((pr + HALF) >>> FRAC);
  assign im_o = ACC_W'((pi + HALF) >>> FRAC);

endmodule

// File: rtl/sbdft_frame_ctl.sv
module sbdft_frame_ctl #(
  parameter int FRAME_LEN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  output logic take_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign take_o = valid_i & (active_q | start_i);
  assign last_o = take_o & ~start_i & (cnt_q == CNT_W'(FRAME_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= valid_i ? CNT_W'(1) : '0;
    end else if (take_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sbin_dft_kernel.sv
module sbin_dft_kernel #(
  parameter int FRAME_LEN = 1024,
  parameter int DATA_W    = 16,
  parameter int COEF_FRAC = 15,
  parameter int K_W       = $clog2(FRAME_LEN),
  parameter int ACC_W     = DATA_W + K_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [K_W-1:0]           bin_i,
  output logic signed [ACC_W-1:0]  re_o,
  output logic signed [ACC_W-1:0]  im_o,
  output logic                     done_o
);
  localparam int COEF_W = COEF_FRAC + 2;

  logic [K_W-1:0]           bin_q, bin_sel;
  logic signed [COEF_W-1:0] cos_w, sin_w;
  logic signed [ACC_W-1:0]  acc_re_q, acc_im_q;
  logic signed [ACC_W-1:0]  base_re, base_im, nxt_re, nxt_im;
  logic                     take, last;

  // the sample arriving with start_i already needs the new bin's coefficient
  assign bin_sel = start_i ? bin_i : bin_q;
  assign base_re = start_i ? '0 : acc_re_q;
  assign base_im = start_i ? '0 : acc_im_q;

  sbdft_twiddle #(
    .FRAME_LEN(FRAME_LEN), .COEF_FRAC(COEF_FRAC), .K_W(K_W), .COEF_W(COEF_W)
  ) u_twid (
    .k_i(bin_sel), .cos_o(cos_w), .sin_o(sin_w)
  );

  sbdft_rot_step #(
    .ACC_W(ACC_W), .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(COEF_FRAC)
  ) u_rot (
    .s_re_i(base_re), .s_im_i(base_im), .x_i(sample_i),
    .c_i(cos_w), .s_i(sin_w), .re_o(nxt_re), .im_o(nxt_im)
  );

  sbdft_frame_ctl #(.FRAME_LEN(FRAME_LEN)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i),
    .take_o(take), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q    <= '0;
      acc_re_q <= '0;
      acc_im_q <= '0;
      re_o     <= '0;
      im_o     <= '0;
      done_o   <= 1'b0;
    end else begin
      if (start_i) bin_q <= bin_i;
      if (take) begin
        acc_re_q <= nxt_re;
        acc_im_q <= nxt_im;
      end else if (start_i) begin
        acc_re_q <= '0;
        acc_im_q <= '0;
      end
      if (start_i) begin
        re_o   <= '0;
        im_o   <= '0;
        done_o <= 1'b0;
      end else begin
        done_o <= last;
        if (last) begin
          re_o <= nxt_re;
          im_o <= nxt_im;
        end
      end
    end
  end

endmodule

// File: rtl/sbin_dft_kernel_chk.sv
module sbin_dft_kernel_chk #(
  parameter int ACC_W = 28,
  parameter int K_W   = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    valid_i,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] re_o,
  input logic signed [ACC_W-1:0] im_o,
  input logic [K_W-1:0]          bin_q,
  input logic signed [ACC_W-1:0] acc_re_q,
  input logic signed [ACC_W-1:0] acc_im_q
);

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));

  // R2
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (re_o == '0 && im_o == '0 && !done_o));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (done_o || ($stable(re_o) && $stable(im_o))));

  // R3
  bin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(bin_q));

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_re_q[ACC_W-1] == acc_re_q[ACC_W-2]) && (acc_im_q[ACC_W-1] == acc_im_q[ACC_W-2]));

endmodule

bind sbin_dft_kernel sbin_dft_kernel_chk #(.ACC_W(ACC_W), .K_W(K_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i),
  .done_o(done_o), .re_o(re_o), .im_o(im_o), .bin_q(bin_q),
  .acc_re_q(acc_re_q), .acc_im_q(acc_im_q)
);

// File: tb/sim_sbin_dft_kernel.sv
`timescale 1ns/1ps
module sim_sbin_dft_kernel;
  localparam int  N  = 1024;
  localparam int  DW = 16;
  localparam int  KW = 10;
  localparam int  AW = 28;
  localparam real TP = 6.283185307179586;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, valid_i = 1'b0;
  logic signed [DW-1:0] sample_i = '0;
  logic [KW-1:0]        bin_i = '0;
  logic signed [AW-1:0] re_o, im_o;
  logic                 done_o;

  sbin_dft_kernel u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i),
    .sample_i(sample_i), .bin_i(bin_i), .re_o(re_o), .im_o(im_o), .done_o(done_o)
  );

  always #2.5 clk_i = ~clk_i;

  int    checks = 0, fails = 0;
  bit    finished = 1'b0;
  string cur = "R1";

  int  xh[N];
  int  m_cnt = 0, m_k = 0;
  bit  m_act = 1'b0, exp_done = 1'b0;
  real exp_re = 0.0, exp_im = 0.0, exp_tol = 0.0;
  logic signed [AW-1:0] prev_re = '0, prev_im = '0;

  function automatic real fabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string what, input real act, input real expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0f expected=%0f", cur, what, act, expv);
    end
  endtask

  task automatic ref_calc();
    real sre = 0.0, sim = 0.0, sabs = 0.0;
    for (int r = 0; r < N; r++) begin
      real ang = TP * m_k * r / N;
      sre += xh[r] * $cos(ang);
      sim -= xh[r] * $sin(ang);
      sabs += fabs(xh[r]);
    end
    exp_re  = sre;
    exp_im  = sim;
    exp_tol = ((m_k % (N / 4)) == 0) ? 0.5 : 0.015 * sabs + N;
  endtask

  // one clock: drive, advance the model, check at the following negedge
  task automatic cyc(input bit st, input bit vl, input int x, input int k);
    start_i  = st;
    valid_i  = vl;
    sample_i = DW'(x);
    bin_i    = KW'(k);
    exp_done = 1'b0;
    if (st) begin
      m_k = k; m_cnt = 0; m_act = 1'b1;
      exp_re = 0.0; exp_im = 0.0; exp_tol = 0.0;
    end
    if (vl && m_act) begin
      xh[m_cnt] = x;
      m_cnt++;
      if (m_cnt == N) begin
        m_act = 1'b0;
        exp_done = 1'b1;
        ref_calc();
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(done_o == exp_done, "R5 done", real'(done_o), real'(exp_done));
    chk(fabs(real'(re_o) - exp_re) <= exp_tol, "R4 re", real'(re_o), exp_re);
    chk(fabs(real'(im_o) - exp_im) <= exp_tol, "R4 im", real'(im_o), exp_im);
    if (!st && !exp_done)
      chk(re_o == prev_re && im_o == prev_im, "R7 hold", real'(re_o), real'(prev_re));
    prev_re = re_o;
    prev_im = im_o;
  endtask

  function automatic int gen(input int kind, input int r, input int k, input int amp);
    case (kind)
      0: return amp;
      1: return (r % 2 == 0) ? amp : -amp;
      2: return $rtoi(amp * $cos(TP * k * r / N + 0.7));
      default: return int'($urandom_range(65535)) - 32768;
    endcase
  endfunction

  // kind: 0 constant, 1 alternating, 2 tone at bin k, 3 random full scale
  task automatic frame(input int k, input int kind, input int amp, input int gap_pct, input int k_alt);
    for (int r = 0; r < N; r++) begin
      if (r != 0)
        while (int'($urandom_range(99)) < gap_pct) cyc(1'b0, 1'b0, 0, k_alt);
      cyc(r == 0, 1'b1, gen(kind, r, k, amp), (r == 0) ? k : k_alt);
    end
    repeat (4) cyc(1'b0, 1'b0, 0, k_alt);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #750000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired in %s", cur);
      summary();
    end
  end

  initial begin
    void'($urandom(7));
    cur = "R1";
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0, "done in reset", real'(done_o), 0.0);
    chk(re_o == '0, "re in reset", real'(re_o), 0.0);
    chk(im_o == '0, "im in reset", real'(im_o), 0.0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cur = "R9";
    frame(0, 0, -32768, 0, 0);
    chk(re_o == -AW'(33554432), "full-scale re", real'(re_o), -33554432.0);

    cur = "R8";
    frame(512, 1, 32767, 0, 512);
    frame(256, 3, 0, 0, 256);
    frame(768, 3, 0, 0, 768);

    cur = "R4";
    frame(1, 2, 8000, 0, 1);
    frame(37, 2, 8000, 0, 37);
    frame(300, 2, 10000, 0, 300);
    frame(700, 2, 10000, 0, 700);
    frame(900, 2, 10000, 0, 900);

    cur = "R6";
    frame(37, 2, 12000, 30, 37);

    cur = "R3";
    frame(900, 2, 8000, 0, 5);

    cur = "R7";
    repeat (40) cyc(1'b0, 1'b1, gen(3, 0, 0, 0), 5);

    cur = "R10";
    for (int r = 0; r < 300; r++) cyc(r == 0, 1'b1, gen(3, r, 0, 0), 256);
    frame(768, 3, 0, 0, 768);

    cur = "R2";
    cyc(1'b1, 1'b0, 0, 3);
    repeat (5) cyc(1'b0, 1'b0, 0, 3);
    for (int r = 0; r < N; r++) cyc(1'b0, 1'b1, gen(2, r, 3, 9000), 3);
    repeat (4) cyc(1'b0, 1'b0, 0, 3);

    summary();
  end

endmodule